// File: doc/BRIEF.md
# Peripheral interrupt aggregator

The block gathers interrupt requests from ten peripheral sources (four GPIO banks, three LED units, SPI, SMBus and a one-wire controller) into one sticky status register and turns them into a single host interrupt line. A global enable bit and six group enable bits decide which latched requests reach the output. The line can signal either as a high level that follows the enabled requests or as a one-cycle pulse on each new assertion.

Software reaches four 16-bit registers through a simple synchronous register bus. A write strobe and a two-bit word index select the register, and read data is returned combinationally. Status bits are cleared by writing ones to them. The block also holds a prescaled time base for an interrupt timer. A 4-bit prescale exponent divides the clock by a power of two. A reload count then sets how many prescaled periods pass between timer ticks.

Top module: `irq_agg_top`

## Requirements
- R1: After reset all four registers read 0, and both host_irq_o and tick_o are low.
- R2: A high level on src_irq_i bit n in a cycle sets status bit n, and the bit stays set after the source drops. The bits are assigned as follows: bits 0..3 are GPIO banks A..D, bits 4..6 are LED 0..2, bit 7 is SPI, bit 8 is SMBus and bit 9 is one-wire.
- R3: Writing to word 1 (status) clears each status bit whose written bit is 1. Written 0 bits leave their status bits unchanged. A source request in the same cycle as its clear leaves the bit set.
- R4: Control bit 0 (word 0) is the global enable. While it is 0, host_irq_o stays low whatever the status holds.
- R5: Control bits 2..7 enable groups of status bits, with 1 meaning enabled. Bit 2 enables GPIO A, bit 3 enables GPIO B, bit 4 enables GPIO C and bit 5 enables GPIO D. Bit 6 enables LED 0..2, and bit 7 enables SPI, SMBus and one-wire. A latched bit whose group is disabled does not drive the output.
- R6: With control bit 1 at 0 (level mode), host_irq_o is high in the cycle after the enabled status becomes nonzero, and it stays high as long as the enabled status stays nonzero.
- R7: With control bit 1 at 1 (edge mode), host_irq_o is high for exactly one cycle after the enabled status goes from zero to nonzero. A new pulse needs the enabled status to return to zero first.
- R8: Word 2 holds the prescale exponent in bits 3..0 and the time base enable in bit 4. A written exponent above 14 is stored as 14.
- R9: While the time base is enabled, tick_o pulses once every (T+1)*2^P clock cycles, where P is the exponent and T is word 3. While the time base is disabled, tick_o stays low.
- R10: The registers sit at word indexes 0 to 3: control, status, prescale and timer set. Bits with no storage read as 0. The control register keeps 8 bits, status keeps 10 bits and prescale keeps 5 bits. The timer-set register keeps 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_irq_i | input | 10 | Peripheral request levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the indexed register |
| host_irq_o | output | 1 | Host interrupt line |
| tick_o | output | 1 | Interrupt timer tick |

## Verification
The assertions assume that src_irq_i is held low while reset is asserted. The sticky-status property looks one cycle back at the request inputs and would fire on a request held during reset. The bench drives every input low before releasing reset. It changes requests and register writes only on falling clock edges, so each request is a clean one-cycle level that the status register captures at the next rising edge. Mode and mask changes are always written before a request is pulsed, which keeps the edge-mode pulse property in its defined window.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int N_SRC   = 10;
  localparam int N_GRP   = 6;
  localparam int CPS_W   = 4;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 2'd2;
  localparam logic [ADDR_W-1:0] A_TSET  = 2'd3;
  localparam int B_GEN   = 0;
  localparam int B_EDGE  = 1;
  localparam int B_GRP0  = 2;

  // group index of a status bit: GPIO banks own one each, LEDs share, serial share
  function automatic int src_group(input int idx);
    if (idx < 4)      return idx;
    else if (idx < 7) return 4;
    else              return 5;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] st_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~clr_i) | set_i;
  end

  assign status_o = st_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] status_i,
  input  logic [7:0]       ctrl_i,
  output logic             irq_o
);
  logic [N_SRC-1:0] src_en;
  logic             pend_d, pend_q, irq_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_en
    assign src_en[i] = ctrl_i[B_GRP0 + src_group(i)];
  end

  assign pend_d = ctrl_i[B_GEN] & (|(status_i & src_en));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= ctrl_i[B_EDGE] ? (pend_d & ~pend_q) : pend_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_timebase.sv
module irq_timebase #(
  parameter int CPS_W  = 4,
  parameter int PRE_W  = 14,
  parameter int TSET_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CPS_W-1:0]  cps_i,
  input  logic [TSET_W-1:0] tset_i,
  output logic              tick_o
);
  logic [PRE_W-1:0]  pre_q, pre_lim;
  logic [TSET_W-1:0] cnt_q;
  logic              base, tick_q;

  assign pre_lim = ~({PRE_W{1'b1}} << cps_i);
  assign base    = (pre_q == pre_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      pre_q  <= base ? '0 : pre_q + 1'b1;
      tick_q <= base && (cnt_q == tset_i);
      if (base) cnt_q <= (cnt_q == tset_i) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TSET_W  = 16,
  parameter int CPS_MAX = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              host_irq_o,
  output logic              tick_o
);
  localparam int PRE_W = CPS_MAX;
  localparam logic [CPS_W-1:0] CPS_TOP = CPS_W'(CPS_MAX);

  logic [7:0]        mask_q;
  logic [CPS_W-1:0]  cps_q;
  logic              tb_en_q;
  logic [TSET_W-1:0] tset_q;
  logic [N_SRC-1:0]  status_q, clr;
  logic [CPS_W-1:0]  cps_wr;

  assign cps_wr = (reg_wdata_i[CPS_W-1:0] > CPS_TOP) ? CPS_TOP : reg_wdata_i[CPS_W-1:0];
  assign clr    = (reg_we_i && reg_addr_i == A_STAT) ? reg_wdata_i[N_SRC-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      cps_q   <= '0;
      tb_en_q <= 1'b0;
      tset_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL:  mask_q <= reg_wdata_i[7:0];
        A_PRESC: begin
          cps_q   <= cps_wr;
          tb_en_q <= reg_wdata_i[CPS_W];
        end
        A_TSET:  tset_q <= reg_wdata_i[TSET_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = DATA_W'(mask_q);
      A_STAT:  reg_rdata_o = DATA_W'(status_q);
      A_PRESC: reg_rdata_o = DATA_W'({tb_en_q, cps_q});
      default: reg_rdata_o = DATA_W'(tset_q);
    endcase
  end

  irq_status_reg #(.N(N_SRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (src_irq_i),
    .clr_i    (clr),
    .status_o (status_q)
  );

  irq_out_gen u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .ctrl_i   (mask_q),
    .irq_o    (host_irq_o)
  );

  irq_timebase #(.CPS_W(CPS_W), .PRE_W(PRE_W), .TSET_W(TSET_W)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tb_en_q),
    .cps_i  (cps_q),
    .tset_i (tset_q),
    .tick_o (tick_o)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_irq_i,
  input logic [N_SRC-1:0] status,
  input logic [7:0]       mask,
  input logic             tb_en,
  input logic [CPS_W-1:0] cps,
  input logic             host_irq_o,
  input logic             tick_o
);
  p_sticky_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & $past(src_irq_i)) == $past(src_irq_i)));

  p_no_spurious_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & ~$past(status) & ~$past(src_irq_i)) == '0));

  p_global_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mask[B_GEN]) |-> !host_irq_o);

  p_edge_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_irq_o && mask[B_EDGE] && $past(mask[B_EDGE])) |=> !host_irq_o);

  p_cps_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cps <= 4'd14);

  p_tick_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tb_en) |-> !tick_o);
endmodule

bind irq_agg_top irq_agg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_irq_i  (src_irq_i),
  .status     (status_q),
  .mask       (mask_q),
  .tb_en      (tb_en_q),
  .cps        (cps_q),
  .host_irq_o (host_irq_o),
  .tick_o     (tick_o)
);

// File: tb/irq_agg_top_bench.sv
module irq_agg_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  src_irq_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        host_irq_o, tick_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_agg_top u_irq_agg_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_irq_i(src_irq_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .host_irq_o(host_irq_o), .tick_o(tick_o)
  );

  // {ctrl[7:0], src[9:0], exp_status[9:0], exp_irq}
  localparam logic [28:0] VEC [10] = '{
    {8'h01, 10'h001, 10'h001, 1'b0},
    {8'h05, 10'h001, 10'h001, 1'b1},
    {8'h05, 10'h002, 10'h002, 1'b0},
    {8'h09, 10'h002, 10'h002, 1'b1},
    {8'h11, 10'h004, 10'h004, 1'b1},
    {8'h21, 10'h008, 10'h008, 1'b1},
    {8'h41, 10'h020, 10'h020, 1'b1},
    {8'h81, 10'h100, 10'h100, 1'b1},
    {8'h80, 10'h200, 10'h200, 1'b0},
    {8'h3D, 10'h1F0, 10'h1F0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [9:0] s);
    @(negedge clk_i);
    src_irq_i = s;
    @(negedge clk_i);
    src_irq_i = '0;
  endtask

  task automatic period(output int n);
    int guard = 0;
    n = 0;
    while (!tick_o && guard < 2000) begin @(negedge clk_i); guard++; end
    do begin @(negedge clk_i); n++; end while (!tick_o && n < 2000);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    int ticks;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg reset", d, 0);
    end
    chk("R1 irq reset", host_irq_o, 0);
    chk("R1 tick reset", tick_o, 0);

    // R2 R4 R5 R6 vector table, level mode
    for (int i = 0; i < 10; i++) begin
      wr(2'd1, 16'h03FF);
      wr(2'd0, {8'h00, VEC[i][28:21]});
      pulse(VEC[i][20:11]);
      @(negedge clk_i);
      chk("R5 R6 irq level", host_irq_o, VEC[i][0]);
      rd(2'd1, d);
      chk("R2 status latched", d, {6'h0, VEC[i][10:1]});
    end

    // R6 level holds while status stays
    wr(2'd1, 16'h03FF);
    wr(2'd0, 16'h0005);
    pulse(10'h001);
    repeat (5) @(negedge clk_i);
    chk("R6 level held", host_irq_o, 1);
    wr(2'd1, 16'h0001);
    @(negedge clk_i);
    chk("R6 level drops after clear", host_irq_o, 0);

    // R4 global enable off masks everything
    wr(2'd0, 16'h00FC);
    pulse(10'h3FF);
    @(negedge clk_i);
    chk("R4 global off", host_irq_o, 0);

    // R3 clear semantics
    wr(2'd1, 16'h0000);
    rd(2'd1, d);
    chk("R3 zero write no effect", d, 16'h03FF);
    wr(2'd1, 16'h0204);
    rd(2'd1, d);
    chk("R3 w1c selective", d, 16'h01FB);
    wr(2'd1, 16'h03FF);
    @(negedge clk_i);
    src_irq_i = 10'h008; reg_addr_i = 2'd1; reg_wdata_i = 16'h0008; reg_we_i = 1'b1;
    @(negedge clk_i);
    src_irq_i = '0; reg_we_i = 1'b0;
    rd(2'd1, d);
    chk("R3 set beats clear", d, 16'h0008);

    // R7 edge mode
    wr(2'd1, 16'h03FF);
    wr(2'd0, 16'h0007);
    pulse(10'h001);
    @(negedge clk_i);
    chk("R7 edge pulse high", host_irq_o, 1);
    @(negedge clk_i);
    chk("R7 edge pulse one cycle", host_irq_o, 0);
    wr(2'd0, 16'h000F);
    pulse(10'h002);
    @(negedge clk_i);
    chk("R7 no pulse while pending", host_irq_o, 0);
    wr(2'd1, 16'h0003);
    pulse(10'h002);
    @(negedge clk_i);
    chk("R7 new pulse after idle", host_irq_o, 1);

    // R8 prescale field
    wr(2'd2, 16'h001F);
    rd(2'd2, d);
    chk("R8 saturate 15", d, 16'h001E);
    wr(2'd2, 16'h000F);
    rd(2'd2, d);
    chk("R8 saturate no enable", d, 16'h000E);
    wr(2'd2, 16'h0005);
    rd(2'd2, d);
    chk("R8 plain value", d, 16'h0005);

    // R10 widths and map
    wr(2'd0, 16'hFFFF);
    rd(2'd0, d);
    chk("R10 ctrl width", d, 16'h00FF);
    wr(2'd3, 16'hABCD);
    rd(2'd3, d);
    chk("R10 tset width", d, 16'hABCD);
    wr(2'd0, 16'h0000);

    // R9 time base
    wr(2'd3, 16'd3);
    wr(2'd2, 16'h0012);
    period(n);
    period(n);
    chk("R9 period P2 T3", n, 16);
    wr(2'd3, 16'd0);
    wr(2'd2, 16'h0010);
    period(n);
    period(n);
    chk("R9 period P0 T0", n, 1);
    wr(2'd3, 16'd1);
    wr(2'd2, 16'h0013);
    period(n);
    period(n);
    chk("R9 period P3 T1", n, 16);
    wr(2'd2, 16'h0003);
    @(negedge clk_i);
    ticks = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (tick_o) ticks++;
    end
    chk("R9 disabled no tick", ticks, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule